// File: doc/BRIEF.md
# Frame Processing Sequencer

This block is a small microcoded controller that walks through the fields of a network frame as 16-bit halfwords arrive from a data source. It holds its program in an internal register array that is loaded before the block runs. Each cycle it reads one fixed-format instruction at the program counter and executes it in that same cycle. There is no pipeline. A data-consuming instruction raises a request-next-data output. A halfword counts as taken only on an edge where that request is high and the source's data-valid strobe is also high.

On every taken halfword the block emits the instruction's strobe mask to the neighbouring checksum and decoder units. A loop counter lets one instruction span a run of halfwords. Conditional jumps follow a match flag returned by the decoder, so the program can branch on frame type.

Top module: `fseq_top`

## Requirements
- R1: While the synchronous reset is high, the program counter goes to 0 and the loop counter is cleared. After reset is released, fetch starts at address 0.
- R2: An instruction word is laid out, from most significant bit down, as opcode (2 bits), loop count (LC_W bits), strobe mask (STB_W bits) and branch target (AW bits). With the defaults these occupy bits [14:13], [12:9], [8:5] and [4:0]. The opcodes are STEP=0, JUMP=1, NEXT=2 and HALT=3.
- R3: A STEP whose effective count is 0, 1 or 2 holds the program counter while data-valid is low and emits no strobe. On the edge where data-valid is high, it advances the program counter by one. In that same cycle the strobe output equals the mask.
- R4: A STEP with count N greater than 2 takes N-1 halfwords. The loop counter decrements on each taken halfword, and the program counter holds until the counter reaches 2. The next taken halfword then advances the program counter. Every taken halfword drives the mask on the strobe output.
- R5: request-next-data is high exactly while the current instruction is a STEP. A data-valid pulse while the request is low produces no strobe and does not change program flow.
- R6: A JUMP loads the program counter from the branch target when the match flag is high, and otherwise advances by one. It takes a single cycle and consumes no data.
- R7: A NEXT advances the program counter by one in a single cycle without data. A HALT holds the program counter indefinitely and keeps the request low.
- R8: Advancing from the last instruction address wraps the program counter to 0.
- R9: A word written through the load port at an address is the instruction fetched there afterwards.
- R10: A reset that arrives in the middle of a multi-halfword STEP discards the partial count. The next execution of that STEP takes its full N-1 halfwords again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dv_i | input | 1 | Data-valid strobe from the halfword source |
| match_i | input | 1 | Match flag from the frame decoder, used by JUMP |
| imem_we_i | input | 1 | Instruction memory write enable |
| imem_addr_i | input | AW (5) | Instruction memory write address |
| imem_wdata_i | input | IW (15) | Instruction word to write |
| req_next_o | output | 1 | Request for the next halfword; the source may present data only while it is high |
| stb_o | output | STB_W (4) | Per-field strobes to the checksum and decoder units, valid on taken halfwords |
| pc_o | output | AW (5) | Current program counter |

## Verification
The assertions assume the instruction word at the current program counter is not rewritten in the cycle it executes. The bench keeps to this by loading the array only while reset is high. The assertions also assume data-valid and the match flag are settled, known values at every edge after reset. The bench drives both on the falling edge and gives them defined levels in every cycle, including cycles where the request is low. No assertion assumes that the source honours the request. The bench deliberately raises data-valid while the request is low, so that the block's own gating is what gets checked.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   localparam int OPC_W = 2;

   typedef enum logic [OPC_W-1:0] {
      OP_STEP = 2'd0,
      OP_JUMP = 2'd1,
      OP_NEXT = 2'd2,
      OP_HALT = 2'd3
   } op_e;

endpackage

// File: rtl/fseq_imem.sv
module fseq_imem #(
   parameter int DEPTH  = 32,
   parameter int WORD_W = 15,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [WORD_W-1:0] rdata_o
);

   logic [WORD_W-1:0] rows [DEPTH];

   generate
      if (DEPTH != (1 << AW)) begin : g_depth_bad
         $error("fseq_imem: DEPTH must be a power of two");
      end
      for (genvar r = 0; r < DEPTH; r++) begin : g_row
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (we_i && (waddr_i == AW'(r))) begin
               word_q <= wdata_i;
            end
         end
         assign rows[r] = word_q;
      end
   endgenerate

   assign rdata_o = rows[raddr_i];

endmodule

// File: rtl/fseq_decode.sv
module fseq_decode
   import fseq_pkg::*;
#(
   parameter int AW    = 5,
   parameter int LC_W  = 4,
   parameter int STB_W = 4,
   localparam int IW   = OPC_W + LC_W + STB_W + AW,
   localparam int TGT_LO  = 0,
   localparam int MASK_LO = TGT_LO + AW,
   localparam int CNT_LO  = MASK_LO + STB_W,
   localparam int OP_LO   = CNT_LO + LC_W
) (
   input  logic [IW-1:0]    instr_i,
   output op_e              op_o,
   output logic [LC_W-1:0]  cnt_o,
   output logic [STB_W-1:0] mask_o,
   output logic [AW-1:0]    tgt_o
);

   always_comb begin
      op_o   = op_e'(instr_i[OP_LO +: OPC_W]);
      cnt_o  = instr_i[CNT_LO +: LC_W];
      mask_o = instr_i[MASK_LO +: STB_W];
      tgt_o  = instr_i[TGT_LO +: AW];
   end

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
   import fseq_pkg::*;
#(
   parameter int AW    = 5,
   parameter int LC_W  = 4,
   parameter int STB_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  op_e              op_i,
   input  logic [LC_W-1:0]  cnt_i,
   input  logic [STB_W-1:0] mask_i,
   input  logic [AW-1:0]    tgt_i,
   input  logic             dv_i,
   input  logic             match_i,
   output logic             req_o,
   output logic [STB_W-1:0] stb_o,
   output logic [AW-1:0]    pc_o
);

   localparam logic [LC_W-1:0] LC_SINGLE_MAX = LC_W'(2);

   logic [AW-1:0]   pc_q, pc_d;
   logic [LC_W-1:0] lc_q, lc_d;
   logic            run_q, run_d;
   logic            is_step, accept, long_run;
   logic [LC_W-1:0] eff_cnt;

   always_comb begin
      is_step  = (op_i == OP_STEP);
      accept   = is_step && dv_i;
      eff_cnt  = run_q ? lc_q : cnt_i;
      long_run = (eff_cnt > LC_SINGLE_MAX);
   end

   always_comb begin
      pc_d  = pc_q;
      lc_d  = '0;
      run_d = 1'b0;
      unique case (op_i)
         OP_STEP: begin
            lc_d  = lc_q;
            run_d = run_q;
            if (accept) begin
               if (long_run) begin
                  lc_d  = eff_cnt - 1'b1;
                  run_d = 1'b1;
               end else begin
                  pc_d  = pc_q + 1'b1;
                  lc_d  = '0;
                  run_d = 1'b0;
               end
            end
         end
         OP_JUMP: pc_d = match_i ? tgt_i : pc_q + 1'b1;
         OP_NEXT: pc_d = pc_q + 1'b1;
         OP_HALT: pc_d = pc_q;
         default: pc_d = pc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         lc_q  <= '0;
         run_q <= 1'b0;
      end else begin
         pc_q  <= pc_d;
         lc_q  <= lc_d;
         run_q <= run_d;
      end
   end

   generate
      for (genvar b = 0; b < STB_W; b++) begin : g_stb
         assign stb_o[b] = mask_i[b] & accept;
      end
   endgenerate

   assign req_o = is_step;
   assign pc_o  = pc_q;

   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (pc_q == '0 && lc_q == '0 && !run_q));

   // R3
   a_r3_hold_without_data: assert property (@(posedge clk) disable iff (rst)
      (is_step && !dv_i) |=> $stable(pc_q));

   // R3
   a_r3_single_advance: assert property (@(posedge clk) disable iff (rst)
      (accept && !long_run) |=> (pc_q == $past(pc_q) + 1'b1));

   // R4
   a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
      (accept && run_q && lc_q > LC_SINGLE_MAX) |=> (lc_q == $past(lc_q) - 1'b1));

   // R4
   a_r4_pc_held_in_run: assert property (@(posedge clk) disable iff (rst)
      (accept && long_run) |=> $stable(pc_q));

   // R6
   a_r6_jump_taken: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_JUMP && match_i) |=> (pc_q == $past(tgt_i)));

   // R7
   a_r7_halt_holds: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_HALT) |=> $stable(pc_q));

endmodule

// File: rtl/fseq_top.sv
module fseq_top
   import fseq_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int LC_W  = 4,
   parameter int STB_W = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int IW   = OPC_W + LC_W + STB_W + AW
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dv_i,
   input  logic             match_i,
   input  logic             imem_we_i,
   input  logic [AW-1:0]    imem_addr_i,
   input  logic [IW-1:0]    imem_wdata_i,
   output logic             req_next_o,
   output logic [STB_W-1:0] stb_o,
   output logic [AW-1:0]    pc_o
);

   generate
      if (LC_W < 2) begin : g_lc_bad
         $error("fseq_top: LC_W must hold the value 2");
      end
      if (STB_W < 1) begin : g_stb_bad
         $error("fseq_top: STB_W must be at least 1");
      end
      if (DEPTH < 4) begin : g_depth_bad
         $error("fseq_top: DEPTH must be at least 4");
      end
   endgenerate

   logic [IW-1:0]    instr;
   op_e              op;
   logic [LC_W-1:0]  cnt;
   logic [STB_W-1:0] mask;
   logic [AW-1:0]    tgt;

   fseq_imem #(.DEPTH(DEPTH), .WORD_W(IW)) u_imem (
      .clk     (clk),
      .we_i    (imem_we_i),
      .waddr_i (imem_addr_i),
      .wdata_i (imem_wdata_i),
      .raddr_i (pc_o),
      .rdata_o (instr)
   );

   fseq_decode #(.AW(AW), .LC_W(LC_W), .STB_W(STB_W)) u_decode (
      .instr_i (instr),
      .op_o    (op),
      .cnt_o   (cnt),
      .mask_o  (mask),
      .tgt_o   (tgt)
   );

   fseq_ctrl #(.AW(AW), .LC_W(LC_W), .STB_W(STB_W)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .op_i    (op),
      .cnt_i   (cnt),
      .mask_i  (mask),
      .tgt_i   (tgt),
      .dv_i    (dv_i),
      .match_i (match_i),
      .req_o   (req_next_o),
      .stb_o   (stb_o),
      .pc_o    (pc_o)
   );

   // R5
   a_r5_no_strobe_without_req: assert property (@(posedge clk) disable iff (rst)
      !req_next_o |-> (stb_o == '0));

endmodule

// File: tb/test_fseq_top.sv
module test_fseq_top;

   localparam int AW = 5;
   localparam int IW = 15;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          dv_i = 1'b0;
   logic          match_i = 1'b0;
   logic          imem_we_i = 1'b0;
   logic [AW-1:0] imem_addr_i = '0;
   logic [IW-1:0] imem_wdata_i = '0;
   logic          req_next_o;
   logic [3:0]    stb_o;
   logic [AW-1:0] pc_o;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   fseq_top i_fseq_top (
      .clk, .rst, .dv_i, .match_i, .imem_we_i, .imem_addr_i,
      .imem_wdata_i, .req_next_o, .stb_o, .pc_o
   );

   // opcodes and field layout as in R2
   function automatic logic [IW-1:0] mk(input logic [1:0] op, input logic [3:0] cnt,
                                        input logic [3:0] mask, input logic [4:0] tgt);
      return {op, cnt, mask, tgt};
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [IW-1:0] w);
      imem_we_i = 1'b1; imem_addr_i = AW'(a); imem_wdata_i = w;
      @(posedge clk); @(negedge clk);
      imem_we_i = 1'b0;
   endtask

   // one cycle: drive, sample combinational outputs, clock
   task automatic cyc(input logic dv, input logic m, output logic rq, output logic [3:0] sb);
      dv_i = dv; match_i = m;
      #1; rq = req_next_o; sb = stb_o;
      @(posedge clk); @(negedge clk);
      dv_i = 1'b0; match_i = 1'b0;
   endtask

   task automatic load_main;
      rst = 1'b1;
      for (int a = 0; a < 32; a++) wr(a, mk(2'd3, 4'd0, 4'd0, 5'd0));
      wr(0,  mk(2'd0, 4'd0, 4'b0001, 5'd0));
      wr(1,  mk(2'd0, 4'd5, 4'b0010, 5'd0));
      wr(2,  mk(2'd1, 4'd0, 4'b1111, 5'd6));
      wr(3,  mk(2'd1, 4'd0, 4'b0000, 5'd6));
      wr(6,  mk(2'd0, 4'd2, 4'b0100, 5'd0));
      wr(7,  mk(2'd1, 4'd0, 4'b0000, 5'd30));
      wr(30, mk(2'd0, 4'd3, 4'b1000, 5'd0));
      wr(31, mk(2'd2, 4'd0, 4'b0000, 5'd0));
      rst = 1'b0;
   endtask

   task automatic t_reset;
      logic rq; logic [3:0] sb;
      load_main();
      check(pc_o == 0, "R1 pc after reset", pc_o, 0);
      cyc(1'b0, 1'b0, rq, sb);
      check(rq == 1'b1, "R9 loaded STEP at 0 requests data", rq, 1);
      check(sb == 4'd0, "R1 no strobe idle", sb, 0);
   endtask

   task automatic t_step_hold;
      logic rq; logic [3:0] sb;
      for (int i = 0; i < 3; i++) begin
         cyc(1'b0, 1'b0, rq, sb);
         check(sb == 4'd0 && pc_o == 0, "R3 hold without data", pc_o, 0);
      end
      cyc(1'b1, 1'b0, rq, sb);
      check(sb == 4'b0001, "R3 strobe equals mask", sb, 1);
      check(pc_o == 1, "R3 advance on data", pc_o, 1);
   endtask

   task automatic t_loop;
      logic rq; logic [3:0] sb;
      cyc(1'b1, 1'b0, rq, sb);
      check(sb == 4'b0010 && pc_o == 1, "R4 first of run", pc_o, 1);
      cyc(1'b0, 1'b0, rq, sb);
      check(sb == 4'd0 && pc_o == 1, "R4 gap no strobe", sb, 0);
      cyc(1'b1, 1'b0, rq, sb);
      check(sb == 4'b0010 && pc_o == 1, "R4 second of run", pc_o, 1);
      cyc(1'b1, 1'b0, rq, sb);
      check(sb == 4'b0010 && pc_o == 1, "R4 third of run", pc_o, 1);
      cyc(1'b1, 1'b0, rq, sb);
      check(sb == 4'b0010 && pc_o == 2, "R4 fourth halfword leaves run", pc_o, 2);
   endtask

   task automatic t_jump;
      logic rq; logic [3:0] sb;
      cyc(1'b1, 1'b0, rq, sb);
      check(rq == 1'b0 && sb == 4'd0, "R5 data ignored while req low", sb, 0);
      check(pc_o == 3, "R6 jump not taken", pc_o, 3);
      cyc(1'b0, 1'b1, rq, sb);
      check(pc_o == 6, "R6 jump taken", pc_o, 6);
      cyc(1'b1, 1'b0, rq, sb);
      check(sb == 4'b0100 && pc_o == 7, "R3 count 2 takes one halfword", pc_o, 7);
   endtask

   task automatic t_wrap;
      logic rq; logic [3:0] sb;
      cyc(1'b0, 1'b1, rq, sb);
      check(pc_o == 30, "R6 jump to high address", pc_o, 30);
      cyc(1'b1, 1'b0, rq, sb);
      check(sb == 4'b1000 && pc_o == 30, "R4 count 3 holds after first", pc_o, 30);
      cyc(1'b1, 1'b0, rq, sb);
      check(sb == 4'b1000 && pc_o == 31, "R4 count 3 leaves after second", pc_o, 31);
      cyc(1'b0, 1'b0, rq, sb);
      check(rq == 1'b0, "R7 NEXT keeps req low", rq, 0);
      check(pc_o == 0, "R8 wrap to 0", pc_o, 0);
   endtask

   task automatic t_reset_mid;
      logic rq; logic [3:0] sb;
      cyc(1'b1, 1'b0, rq, sb);
      cyc(1'b1, 1'b0, rq, sb);
      cyc(1'b1, 1'b0, rq, sb);
      check(pc_o == 1, "R10 inside run before reset", pc_o, 1);
      rst = 1'b1;
      cyc(1'b0, 1'b0, rq, sb);
      rst = 1'b0;
      check(pc_o == 0, "R10 reset mid run", pc_o, 0);
      cyc(1'b1, 1'b0, rq, sb);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, rq, sb);
      check(pc_o == 1, "R10 full count after reset", pc_o, 1);
      cyc(1'b1, 1'b0, rq, sb);
      check(pc_o == 2, "R10 run ends at full count", pc_o, 2);
   endtask

   task automatic t_halt;
      logic rq; logic [3:0] sb;
      rst = 1'b1;
      wr(0, mk(2'd3, 4'd0, 4'b1111, 5'd9));
      rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         cyc(1'b1, 1'b1, rq, sb);
         check(rq == 1'b0 && sb == 4'd0, "R7 HALT no request", sb, 0);
         check(pc_o == 0, "R9 rewritten word halts", pc_o, 0);
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_step_hold();
      t_loop();
      t_jump();
      t_wrap();
      t_reset_mid();
      t_halt();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule